// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block forms the effective 12-bit data memory address for each memory operand of a small 8-bit microcontroller core. It also says where the operation's result goes. A byte- or bit-oriented operation carries an 8-bit file field and an access bit. When the access bit is 1, the address is made from the bank select register and the field. When it is 0, the field maps into a fixed access bank. That bank joins the bottom of data memory to the special function register region at the top.

Two-operand moves carry complete source and destination addresses, and for them the bank select register plays no part. Indirect operations take their address from one of three 12-bit pointer registers. Such an operation can leave the pointer as it is, step it up or down by one after the access, or address the pointer plus a signed offset. The pointers sit in the special function register space. Ordinary register writes and reads through a byte port reach them there.

Top module: `dmag_addr_gen`

## Requirements
- R1: For a direct operation (op_kind = 0) with acc_bit = 1, eff_addr equals {bank_sel, file_addr}.
- R2: For a direct operation with acc_bit = 0, eff_addr is {4'h0, file_addr} when file_addr < 8'h60 and {4'hF, file_addr} otherwise, whatever bank_sel holds.
- R3: For a move operation (op_kind = 1), eff_addr equals mv_src and mv_dst_addr equals mv_dst, whatever bank_sel holds, and to_wreg is 0. For every other operation mv_dst_addr is 0.
- R4: For direct operations, and for indirect operations (op_kind = 2) with a valid pointer select, to_wreg equals the inverse of dst_bit. When op_valid is 0, when op_kind = 3, or when ptr_sel is 3 or above, to_wreg and eff_addr are 0.
- R5: For an indirect operation, ptr_mode 0 (hold), 1 (post-increment) and 2 (post-decrement) give eff_addr equal to the selected pointer's value before any update. Mode 3 gives the pointer plus the sign-extended ptr_off, modulo 4096. Modes 0 and 3 leave the pointer unchanged.
- R6: Post-increment and post-decrement change the selected pointer by one modulo 4096, and the new value is visible on ptr_vals after the clock edge. Pointer k sits at ptr_vals[12k+11:12k].
- R7: The low byte of pointer k is at register address 12'hFE0 + 2k and its high byte at 12'hFE0 + 2k + 1. Writing the high byte loads bits 11:8 from sfr_wdata[3:0] and ignores sfr_wdata[7:4]. Reading the high byte returns zero in bits 7:4. sfr_rhit is 1 only for these six addresses.
- R8: A register-port write to either byte of a pointer in the same cycle as that pointer's automatic step takes priority. The written byte takes sfr_wdata, the other byte keeps its value from before the step, and the step is dropped.
- R9: After reset every pointer is 0.
- R10: Starting a pointer at 12'h100 and post-incrementing it, the accesses cover 12'h100 to 12'h1FF in order. Bit 1 of the high byte first reads as 1 after exactly 256 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A memory operand is presented this cycle |
| op_kind | input | 2 | 0 direct, 1 full-address move, 2 indirect, 3 no operand |
| file_addr | input | 8 | File register field of the operation |
| acc_bit | input | 1 | 1 selects banked addressing, 0 selects access bank |
| dst_bit | input | 1 | 1 writes the result back to the file register, 0 writes it to W |
| bank_sel | input | 4 | Bank select register value |
| mv_src | input | 12 | Full source address of a move |
| mv_dst | input | 12 | Full destination address of a move |
| ptr_sel | input | 2 | Pointer used by an indirect operation |
| ptr_mode | input | 2 | 0 hold, 1 post-increment, 2 post-decrement, 3 offset |
| ptr_off | input | 8 | Signed offset for mode 3 |
| sfr_we | input | 1 | Register-port write strobe |
| sfr_waddr | input | 12 | Register-port write address |
| sfr_wdata | input | 8 | Register-port write data |
| sfr_raddr | input | 12 | Register-port read address |
| sfr_rdata | output | 8 | Read data of a pointer byte, 0 on a miss |
| sfr_rhit | output | 1 | Read address names a pointer byte |
| eff_addr | output | 12 | Effective (source) data address |
| mv_dst_addr | output | 12 | Destination address of a move |
| to_wreg | output | 1 | Result goes to the working register |
| ptr_vals | output | 36 | Current values of all pointers |

## Verification
The bench builds the block with its defaults: an 8-bit field, a 4-bit bank, three pointers at base 12'hFE0 and the access bank split at 8'h60. With these values both access-bank halves can be reached, and so can both ends of the 12-bit pointer range, where stepping wraps. The select value 3 has no pointer behind it, so the invalid-select path can be driven. The base also leaves two unused addresses, 12'hFE6 and 12'hFE7, where register writes must do nothing. Random operations and register-port writes run against a bench model of the pointers, alongside directed wrap, priority and clear-bank cases.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic [1:0] {
    K_DIRECT   = 2'd0,
    K_MOVE     = 2'd1,
    K_INDIRECT = 2'd2,
    K_NONE     = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_OFFS = 2'd3
  } ptr_mode_e;

endpackage

// File: rtl/dmag_bank_map.sv
module dmag_bank_map #(
  parameter int FW = 8,
  parameter int BW = 4,
  parameter logic [FW-1:0] SPLIT = 8'h60
) (
  input  logic [FW-1:0]    file_addr,
  input  logic             acc_bit,
  input  logic [BW-1:0]    bank_sel,
  output logic [FW+BW-1:0] direct_addr
);
  localparam int AW = FW + BW;

  // Fixed access bank: the lower part maps to the bottom of memory,
  // the upper part to the special function register region at the top.
  function automatic logic [AW-1:0] access_map(input logic [FW-1:0] f);
    if (f < SPLIT) return {{BW{1'b0}}, f};
    else           return {{BW{1'b1}}, f};
  endfunction

  function automatic logic [AW-1:0] banked(input logic [BW-1:0] b, input logic [FW-1:0] f);
    return {b, f};
  endfunction

  assign direct_addr = acc_bit ? banked(bank_sel, file_addr) : access_map(file_addr);

endmodule

// File: rtl/dmag_ptr_file.sv
module dmag_ptr_file
  import dmag_pkg::*;
#(
  parameter int NPTR = 3,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int SW = 2,
  parameter logic [AW-1:0] BASE = 12'hFE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic [SW-1:0]        acc_sel,
  input  logic [1:0]           acc_mode,
  input  logic                 sfr_we,
  input  logic [AW-1:0]        sfr_waddr,
  input  logic [DW-1:0]        sfr_wdata,
  input  logic [AW-1:0]        sfr_raddr,
  output logic [DW-1:0]        sfr_rdata,
  output logic                 sfr_rhit,
  output logic [AW-1:0]        cur_ptr,
  output logic                 sel_ok,
  output logic [NPTR*AW-1:0]   ptr_flat
);
  localparam int HW = AW - DW;

  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [NPTR-1:0] upd_en;
  logic [NPTR-1:0] wr_lo_hit;
  logic [NPTR-1:0] wr_hi_hit;
  logic [NPTR-1:0] rd_lo_hit;
  logic [NPTR-1:0] rd_hi_hit;
  logic [NPTR-1:0] acc_hit;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [1:0] m);
    case (m)
      PM_INC:  return p + AW'(1);
      PM_DEC:  return p - AW'(1);
      default: return p;
    endcase
  endfunction

  function automatic logic [AW-1:0] lo_byte_addr(input int k);
    return BASE + AW'(2 * k);
  endfunction

  function automatic logic [AW-1:0] hi_byte_addr(input int k);
    return BASE + AW'(2 * k + 1);
  endfunction

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign acc_hit[k]   = acc_en && (acc_sel == SW'(k));
    assign upd_en[k]    = acc_hit[k] && (acc_mode == PM_INC || acc_mode == PM_DEC);
    assign wr_lo_hit[k] = sfr_we && (sfr_waddr == lo_byte_addr(k));
    assign wr_hi_hit[k] = sfr_we && (sfr_waddr == hi_byte_addr(k));
    assign rd_lo_hit[k] = (sfr_raddr == lo_byte_addr(k));
    assign rd_hi_hit[k] = (sfr_raddr == hi_byte_addr(k));
    assign ptr_flat[k*AW +: AW] = ptr_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[k] <= '0;
      end else if (wr_lo_hit[k] || wr_hi_hit[k]) begin
        if (wr_lo_hit[k]) ptr_q[k][DW-1:0]  <= sfr_wdata;
        if (wr_hi_hit[k]) ptr_q[k][AW-1:DW] <= sfr_wdata[HW-1:0];
      end else if (upd_en[k]) begin
        ptr_q[k] <= step_ptr(ptr_q[k], acc_mode);
      end
    end

    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en[k] && !(wr_lo_hit[k] || wr_hi_hit[k])
      |=> ptr_q[k] == step_ptr($past(ptr_q[k]), $past(acc_mode)));

    // R8
    wr_prio_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_hit[k] |=> ptr_q[k][DW-1:0] == $past(sfr_wdata) && ptr_q[k][AW-1:DW] == $past(ptr_q[k][AW-1:DW]));

    // R8
    wr_prio_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi_hit[k] |=> ptr_q[k][DW-1:0] == $past(ptr_q[k][DW-1:0]));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit[k] && (acc_mode == PM_HOLD || acc_mode == PM_OFFS) && !(wr_lo_hit[k] || wr_hi_hit[k])
      |=> $stable(ptr_q[k]));
  end

  always_comb begin
    sfr_rdata = '0;
    sfr_rhit  = 1'b0;
    for (int k = 0; k < NPTR; k++) begin
      if (rd_lo_hit[k]) begin
        sfr_rdata = ptr_q[k][DW-1:0];
        sfr_rhit  = 1'b1;
      end
      if (rd_hi_hit[k]) begin
        sfr_rdata = {{(DW-HW){1'b0}}, ptr_q[k][AW-1:DW]};
        sfr_rhit  = 1'b1;
      end
    end
  end

  always_comb begin
    cur_ptr = '0;
    sel_ok  = 1'b0;
    for (int k = 0; k < NPTR; k++) begin
      if (acc_sel == SW'(k)) begin
        cur_ptr = ptr_q[k];
        sel_ok  = 1'b1;
      end
    end
  end

  // R7
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_hi_hit) |-> sfr_rhit && sfr_rdata[DW-1:HW] == '0);

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_en));

endmodule

// File: rtl/dmag_addr_gen.sv
module dmag_addr_gen
  import dmag_pkg::*;
#(
  parameter int FW = 8,
  parameter int BW = 4,
  parameter int NPTR = 3,
  parameter int SW = 2,
  parameter logic [FW+BW-1:0] PTR_BASE = 12'hFE0,
  parameter logic [FW-1:0] ACC_SPLIT = 8'h60
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [1:0]                 op_kind,
  input  logic [FW-1:0]              file_addr,
  input  logic                       acc_bit,
  input  logic                       dst_bit,
  input  logic [BW-1:0]              bank_sel,
  input  logic [FW+BW-1:0]           mv_src,
  input  logic [FW+BW-1:0]           mv_dst,
  input  logic [SW-1:0]              ptr_sel,
  input  logic [1:0]                 ptr_mode,
  input  logic [FW-1:0]              ptr_off,
  input  logic                       sfr_we,
  input  logic [FW+BW-1:0]           sfr_waddr,
  input  logic [FW-1:0]              sfr_wdata,
  input  logic [FW+BW-1:0]           sfr_raddr,
  output logic [FW-1:0]              sfr_rdata,
  output logic                       sfr_rhit,
  output logic [FW+BW-1:0]           eff_addr,
  output logic [FW+BW-1:0]           mv_dst_addr,
  output logic                       to_wreg,
  output logic [NPTR*(FW+BW)-1:0]    ptr_vals
);
  localparam int AW = FW + BW;

  logic [AW-1:0] direct_addr;
  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] ind_addr;
  logic          sel_ok;
  logic          ind_en;

  function automatic logic [AW-1:0] ind_target(input logic [AW-1:0] p,
                                               input logic [1:0] m,
                                               input logic [FW-1:0] off);
    if (m == PM_OFFS) return p + {{(AW-FW){off[FW-1]}}, off};
    else              return p;
  endfunction

  dmag_bank_map #(.FW(FW), .BW(BW), .SPLIT(ACC_SPLIT)) u_map (
    .file_addr   (file_addr),
    .acc_bit     (acc_bit),
    .bank_sel    (bank_sel),
    .direct_addr (direct_addr)
  );

  assign ind_en = op_valid && (op_kind == K_INDIRECT);

  dmag_ptr_file #(.NPTR(NPTR), .AW(AW), .DW(FW), .SW(SW), .BASE(PTR_BASE)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (ind_en),
    .acc_sel   (ptr_sel),
    .acc_mode  (ptr_mode),
    .sfr_we    (sfr_we),
    .sfr_waddr (sfr_waddr),
    .sfr_wdata (sfr_wdata),
    .sfr_raddr (sfr_raddr),
    .sfr_rdata (sfr_rdata),
    .sfr_rhit  (sfr_rhit),
    .cur_ptr   (cur_ptr),
    .sel_ok    (sel_ok),
    .ptr_flat  (ptr_vals)
  );

  assign ind_addr = ind_target(cur_ptr, ptr_mode, ptr_off);

  always_comb begin
    eff_addr    = '0;
    mv_dst_addr = '0;
    to_wreg     = 1'b0;
    if (op_valid) begin
      case (op_kind)
        K_DIRECT: begin
          eff_addr = direct_addr;
          to_wreg  = !dst_bit;
        end
        K_MOVE: begin
          eff_addr    = mv_src;
          mv_dst_addr = mv_dst;
        end
        K_INDIRECT: begin
          if (sel_ok) begin
            eff_addr = ind_addr;
            to_wreg  = !dst_bit;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  acc_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == K_DIRECT && !acc_bit
    |-> eff_addr[FW-1:0] == file_addr &&
        (eff_addr[AW-1:FW] == '0 || eff_addr[AW-1:FW] == '1));

  // R1
  banked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == K_DIRECT && acc_bit |-> eff_addr[AW-1:FW] == bank_sel);

  // R3
  move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == K_MOVE |-> !to_wreg && eff_addr == mv_src && mv_dst_addr == mv_dst);

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !to_wreg && eff_addr == '0);

  // R5
  pre_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind_en && sel_ok && ptr_mode != PM_OFFS |-> eff_addr == ptr_vals[ptr_sel*AW +: AW]);

endmodule

// File: tb/test_dmag_addr_gen.sv
`timescale 1ns/1ps
module test_dmag_addr_gen;
  localparam int AW = 12;
  localparam int NP = 3;
  localparam logic [11:0] BASE = 12'hFE0;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [1:0] op_kind;
  logic [7:0] file_addr;
  logic acc_bit, dst_bit;
  logic [3:0] bank_sel;
  logic [11:0] mv_src, mv_dst;
  logic [1:0] ptr_sel, ptr_mode;
  logic [7:0] ptr_off;
  logic sfr_we;
  logic [11:0] sfr_waddr, sfr_raddr;
  logic [7:0] sfr_wdata, sfr_rdata;
  logic sfr_rhit;
  logic [11:0] eff_addr, mv_dst_addr;
  logic to_wreg;
  logic [NP*AW-1:0] ptr_vals;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] m_ptr [NP];

  always #10 clk = ~clk;

  dmag_addr_gen i_dmag_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .file_addr(file_addr), .acc_bit(acc_bit), .dst_bit(dst_bit), .bank_sel(bank_sel),
    .mv_src(mv_src), .mv_dst(mv_dst), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode),
    .ptr_off(ptr_off), .sfr_we(sfr_we), .sfr_waddr(sfr_waddr), .sfr_wdata(sfr_wdata),
    .sfr_raddr(sfr_raddr), .sfr_rdata(sfr_rdata), .sfr_rhit(sfr_rhit),
    .eff_addr(eff_addr), .mv_dst_addr(mv_dst_addr), .to_wreg(to_wreg), .ptr_vals(ptr_vals)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected direct address, restated from R1 and R2
  function automatic logic [11:0] exp_direct(input logic [7:0] f, input logic a, input logic [3:0] b);
    if (a) return (12'(b) << 8) | 12'(f);
    if (f >= 8'h60) return 12'hF00 | 12'(f);
    return 12'(f);
  endfunction

  function automatic logic [11:0] add_signed(input logic [11:0] p, input logic [7:0] o);
    int s;
    s = $signed(o);
    return 12'((int'(p) + s + 4096) % 4096);
  endfunction

  function automatic void exp_read(input logic [11:0] ra, output logic [7:0] d, output logic h);
    int off;
    d = 8'h00; h = 1'b0;
    off = int'(ra) - int'(BASE);
    if (off >= 0 && off < 2 * NP) begin
      h = 1'b1;
      if (off % 2 == 0) d = m_ptr[off / 2][7:0];
      else              d = {4'h0, m_ptr[off / 2][11:8]};
    end
  endfunction

  task automatic idle();
    op_valid = 0; op_kind = 2'd3; file_addr = 0; acc_bit = 0; dst_bit = 0;
    bank_sel = 0; mv_src = 0; mv_dst = 0; ptr_sel = 0; ptr_mode = 0; ptr_off = 0;
    sfr_we = 0; sfr_waddr = 0; sfr_wdata = 0; sfr_raddr = 0;
  endtask

  // Inputs must already be driven just after a falling edge.
  task automatic run(input string tag);
    logic [11:0] e_eff, e_mvd;
    logic e_w, e_h;
    logic [7:0] e_d;
    logic [11:0] nxt [NP];
    #2;
    e_eff = 0; e_mvd = 0; e_w = 0;
    if (op_valid) begin
      if (op_kind == 2'd0) begin
        e_eff = exp_direct(file_addr, acc_bit, bank_sel); e_w = !dst_bit;
      end else if (op_kind == 2'd1) begin
        e_eff = mv_src; e_mvd = mv_dst;
      end else if (op_kind == 2'd2 && ptr_sel < NP) begin
        e_eff = (ptr_mode == 2'd3) ? add_signed(m_ptr[ptr_sel], ptr_off) : m_ptr[ptr_sel];
        e_w = !dst_bit;
      end
    end
    chk(eff_addr == e_eff, {tag, " eff_addr"}, 16'(eff_addr), 16'(e_eff));
    chk(mv_dst_addr == e_mvd, {tag, " R3 mv_dst_addr"}, 16'(mv_dst_addr), 16'(e_mvd));
    chk(to_wreg == e_w, {tag, " R4 to_wreg"}, 16'(to_wreg), 16'(e_w));
    exp_read(sfr_raddr, e_d, e_h);
    chk(sfr_rdata == e_d && sfr_rhit == e_h, {tag, " R7 sfr read"},
        {7'd0, sfr_rhit, sfr_rdata}, {7'd0, e_h, e_d});
    for (int k = 0; k < NP; k++) begin
      bit lo, hi;
      nxt[k] = m_ptr[k];
      lo = sfr_we && sfr_waddr == BASE + 12'(2 * k);
      hi = sfr_we && sfr_waddr == BASE + 12'(2 * k + 1);
      if (lo) nxt[k][7:0] = sfr_wdata;
      if (hi) nxt[k][11:8] = sfr_wdata[3:0];
      if (!lo && !hi && op_valid && op_kind == 2'd2 && ptr_sel == 2'(k)) begin
        if (ptr_mode == 2'd1) nxt[k] = m_ptr[k] + 12'd1;
        if (ptr_mode == 2'd2) nxt[k] = m_ptr[k] - 12'd1;
      end
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < NP; k++) begin
      m_ptr[k] = nxt[k];
      chk(ptr_vals[k*AW +: AW] == m_ptr[k], {tag, " R6 R8 pointer"},
          16'(ptr_vals[k*AW +: AW]), 16'(m_ptr[k]));
    end
  endtask

  task automatic sfr_write(input logic [11:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); idle(); sfr_we = 1; sfr_waddr = a; sfr_wdata = d; run(tag);
  endtask

  task automatic set_ptr(input int k, input logic [11:0] v);
    sfr_write(BASE + 12'(2 * k), v[7:0], "R7 set lo");
    sfr_write(BASE + 12'(2 * k + 1), {4'h0, v[11:8]}, "R7 set hi");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0;
    for (int k = 0; k < NP; k++) m_ptr[k] = 12'h000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9 reset state
    chk(ptr_vals == '0, "R9 reset pointers", 16'(ptr_vals[15:0]), 16'h0);

    // R1 banked
    @(negedge clk); idle(); op_valid = 1; op_kind = 0; acc_bit = 1; bank_sel = 4'h5;
    file_addr = 8'h34; dst_bit = 1; run("R1 banked");
    // R2 access bank boundary, bank ignored
    @(negedge clk); idle(); op_valid = 1; op_kind = 0; acc_bit = 0; bank_sel = 4'h7;
    file_addr = 8'h5F; run("R2 access low");
    @(negedge clk); idle(); op_valid = 1; op_kind = 0; acc_bit = 0; bank_sel = 4'h7;
    file_addr = 8'h60; dst_bit = 1; run("R2 access high");
    // R3 full-address move
    @(negedge clk); idle(); op_valid = 1; op_kind = 1; bank_sel = 4'h9; acc_bit = 1;
    mv_src = 12'h123; mv_dst = 12'hABC; run("R3 move");
    // R4 no operand
    @(negedge clk); idle(); op_valid = 1; op_kind = 3; dst_bit = 0; run("R4 none");

    // R7 high byte upper nibble ignored
    sfr_write(BASE, 8'h00, "R7 lo");
    sfr_write(BASE + 12'd1, 8'hF1, "R7 hi");
    @(negedge clk); idle(); sfr_raddr = BASE + 12'd1; run("R7 read hi");
    @(negedge clk); idle(); sfr_we = 1; sfr_waddr = BASE + 12'd6; sfr_wdata = 8'hAA;
    sfr_raddr = BASE + 12'd6; run("R7 unused addr");

    // R10 clear-bank loop
    begin
      int n = 0;
      bit fin = 0;
      while (!fin && n < 300) begin
        @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 0; ptr_mode = 1;
        dst_bit = 1;
        #2;
        chk(eff_addr == 12'h100 + 12'(n), "R10 loop address", 16'(eff_addr), 16'(12'h100 + 12'(n)));
        run("R10 loop");
        n++;
        @(negedge clk); idle(); sfr_raddr = BASE + 12'd1; #2;
        fin = sfr_rdata[1];
        run("R10 poll");
      end
      chk(n == 256, "R10 write count", 16'(n), 16'd256);
    end

    // R6 wrap at both ends
    set_ptr(1, 12'h000);
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 1; ptr_mode = 2; run("R6 dec wrap");
    chk(ptr_vals[AW +: AW] == 12'hFFF, "R6 dec wrap value", 16'(ptr_vals[AW +: AW]), 16'hFFF);
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 1; ptr_mode = 1; run("R6 inc wrap");
    chk(ptr_vals[AW +: AW] == 12'h000, "R6 inc wrap value", 16'(ptr_vals[AW +: AW]), 16'h000);

    // R8 write beats step
    set_ptr(2, 12'h0FF);
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 2; ptr_mode = 1;
    sfr_we = 1; sfr_waddr = BASE + 12'd4; sfr_wdata = 8'h10; run("R8 priority");
    chk(ptr_vals[2*AW +: AW] == 12'h010, "R8 priority value", 16'(ptr_vals[2*AW +: AW]), 16'h010);

    // R5 offset modes and invalid select
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 2; ptr_mode = 3; ptr_off = 8'hF0;
    run("R5 negative offset");
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 2; ptr_mode = 3; ptr_off = 8'h7F;
    dst_bit = 1; run("R5 positive offset");
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 2; ptr_mode = 0; run("R5 hold");
    @(negedge clk); idle(); op_valid = 1; op_kind = 2; ptr_sel = 3; ptr_mode = 1; run("R4 invalid select");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); idle();
      op_valid  = 1'($urandom_range(0, 7) != 0);
      op_kind   = 2'($urandom_range(0, 3));
      file_addr = 8'($urandom);
      acc_bit   = 1'($urandom);
      dst_bit   = 1'($urandom);
      bank_sel  = 4'($urandom);
      mv_src    = 12'($urandom);
      mv_dst    = 12'($urandom);
      ptr_sel   = 2'($urandom);
      ptr_mode  = 2'($urandom);
      ptr_off   = 8'($urandom);
      sfr_we    = 1'($urandom_range(0, 3) == 0);
      sfr_waddr = BASE + 12'($urandom_range(0, 7));
      sfr_wdata = 8'($urandom);
      sfr_raddr = BASE + 12'($urandom_range(0, 9));
      run("R1 R2 R3 R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule